// File: doc/BRIEF.md
# External Line Wake and Interrupt Router

This block watches a parameterised set of input lines and turns their transitions into interrupt requests, wake events, or both. Every line passes through a two-flop synchronizer and then an edge detector. For each line, the rising edge, the falling edge, or both can be selected as the trigger. A per-line software trigger acts like a detected edge. A trigger on a line whose interrupt enable is set latches a pending bit, and that line's interrupt request stays asserted until software clears the bit. A trigger on a line whose event enable is set produces a one-cycle wake pulse for the sleep controller. All lines share this single pulse output.

Event-only lines never touch the pending bits, so waking through them leaves nothing for software to clean up. The power controller uses a summary pending flag. A request to enter deep stop is granted only while no pending bit is set. Otherwise the request is refused and execution carries on.

Configuration uses a write-only port. Each mask and edge-select vector has its own set address and clear address, so one write changes only the bits that carry a 1.

Top module: `xline_router`

## Requirements
- R1: While rst_n is low and after it is released, irq_req, evt_pulse, any_pend, stop_refuse are 0, and every enable and edge select is cleared.
- R2: A change on line_in[i] is seen through two synchronizer flops. A selected edge changes irq_req/evt_pulse right after the third rising clock edge after the change, and not before.
- R3: The rising select bit enables 0→1 transitions and the falling select bit enables 1→0 transitions. With both bits set, either transition triggers the line. With neither set, the line never triggers from its input.
- R4: A trigger on a line with its event enable set drives evt_pulse high for exactly one cycle, on the clock edge after the trigger is detected. evt_pulse is the OR over all lines.
- R5: A trigger on a line whose interrupt enable is clear never sets that line's pending bit, even when its event enable is set.
- R6: A trigger on a line with its interrupt enable set sets its pending bit. irq_req[i] = pending[i] AND interrupt enable[i], and the bit stays set until cleared.
- R7: A write to address 9 clears each pending bit whose data bit is 1. Data bits that are 0 change nothing. If a trigger and a clear hit the same line in the same cycle, the bit ends set.
- R8: A write to address 8 triggers every line whose data bit is 1, on both the interrupt and the event paths, independent of the edge selects.
- R9: any_pend is the OR of the pending bits. With stop_req high, stop_refuse is 1 and stop_enter is 0 while any_pend is 1; otherwise stop_enter is 1 and stop_refuse is 0. Both are 0 without stop_req.
- R10: Writes set or clear the bits given by 1s in wr_data. The addresses are: 0/1 interrupt enable set/clear, 2/3 event enable set/clear, 4/5 rising select set/clear, 6/7 falling select set/clear. Data bits that are 0 leave bits unchanged. A new setting takes effect from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_in | input | N | Asynchronous input lines |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 4 | Configuration write address |
| wr_data | input | N | Per-line write data |
| stop_req | input | 1 | Request to enter deep stop |
| irq_req | output | N | Per-line interrupt requests |
| evt_pulse | output | 1 | One-cycle wake event |
| any_pend | output | 1 | Some pending bit is set |
| stop_enter | output | 1 | Stop entry granted |
| stop_refuse | output | 1 | Stop entry refused |

## Verification
Two functions can act on the same pending bit in one cycle: a detected edge or software trigger, and a write-1 clear. The directed part times a falling transition so that it is detected in the exact cycle the clear is written, and expects the bit to survive. Random writes to the clear and trigger addresses, mixed with random line toggles, then produce many more collisions. After every clock, the per-cycle model independently predicts irq_req, evt_pulse and the stop outputs.

// File: rtl/xlr_pkg.sv
// Shared definitions for the external line router: write-port address map.
package xlr_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_IMSK_SET = 4'd0,
        RA_IMSK_CLR = 4'd1,
        RA_EMSK_SET = 4'd2,
        RA_EMSK_CLR = 4'd3,
        RA_RISE_SET = 4'd4,
        RA_RISE_CLR = 4'd5,
        RA_FALL_SET = 4'd6,
        RA_FALL_CLR = 4'd7,
        RA_SWTRIG   = 4'd8,
        RA_PCLR     = 4'd9
    } reg_addr_e;
endpackage

// File: rtl/xlr_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; no cross-bit coherency is provided.
module xlr_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the raw input.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= d;
            end
        end else begin : g_next
            // Later stages shift the sample along.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xlr_cfg.sv
// Configuration register file with set/clear addressing.
// Also decodes the software-trigger and pending-clear strobes as one-cycle vectors.
// Assumes writes are single-cycle strobes.
module xlr_cfg
    import xlr_pkg::*;
#(
    parameter int N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [N-1:0]      wr_data,
    output logic [N-1:0]      imask,
    output logic [N-1:0]      emask,
    output logic [N-1:0]      rise_en,
    output logic [N-1:0]      fall_en,
    output logic [N-1:0]      sw_trig,
    output logic [N-1:0]      pend_clr
);
    // Update the masks and edge selects from set/clear writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imask   <= '0;
            emask   <= '0;
            rise_en <= '0;
            fall_en <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                RA_IMSK_SET: imask   <= imask   |  wr_data;
                RA_IMSK_CLR: imask   <= imask   & ~wr_data;
                RA_EMSK_SET: emask   <= emask   |  wr_data;
                RA_EMSK_CLR: emask   <= emask   & ~wr_data;
                RA_RISE_SET: rise_en <= rise_en |  wr_data;
                RA_RISE_CLR: rise_en <= rise_en & ~wr_data;
                RA_FALL_SET: fall_en <= fall_en |  wr_data;
                RA_FALL_CLR: fall_en <= fall_en & ~wr_data;
                default: ;
            endcase
        end
    end

    // Decode the strobe-type addresses into per-line pulses.
    always_comb begin
        sw_trig  = '0;
        pend_clr = '0;
        if (wr_en && wr_addr == RA_SWTRIG) sw_trig  = wr_data;
        if (wr_en && wr_addr == RA_PCLR)   pend_clr = wr_data;
    end
endmodule

// File: rtl/xlr_edge.sv
// Per-line edge detector on synchronized inputs.
// Merges the software trigger into the result.
// Assumes inputs are already synchronous to clk.
module xlr_edge #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sync_in,
    input  logic [N-1:0] rise_en,
    input  logic [N-1:0] fall_en,
    input  logic [N-1:0] sw_trig,
    output logic [N-1:0] trig
);
    logic [N-1:0] prev_q;

    // Hold the previous synchronized level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_in;
    end

    for (genvar i = 0; i < N; i++) begin : g_line
        logic up, down;
        // Classify the transition of this line and apply its selects.
        always_comb begin
            up      = sync_in[i] & ~prev_q[i];
            down    = ~sync_in[i] & prev_q[i];
            trig[i] = (up & rise_en[i]) | (down & fall_en[i]) | sw_trig[i];
        end
    end
endmodule

// File: rtl/xlr_pend.sv
// Per-line pending storage and event pulse generation.
// Pending sets only through the interrupt path, and a trigger beats a clear in the same cycle.
// Event pulses are registered and last one cycle per trigger.
module xlr_pend #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] trig,
    input  logic [N-1:0] imask,
    input  logic [N-1:0] emask,
    input  logic [N-1:0] pend_clr,
    output logic [N-1:0] pend_q,
    output logic [N-1:0] evt_q
);
    for (genvar i = 0; i < N; i++) begin : g_line
        // Pending bit: set by an enabled trigger, cleared by write-1, trigger wins.
        always_ff @(posedge clk) begin
            if (!rst_n) pend_q[i] <= 1'b0;
            else        pend_q[i] <= (pend_q[i] & ~pend_clr[i]) | (trig[i] & imask[i]);
        end
        // Event flop: one-cycle pulse for an event-enabled trigger.
        always_ff @(posedge clk) begin
            if (!rst_n) evt_q[i] <= 1'b0;
            else        evt_q[i] <= trig[i] & emask[i];
        end
    end
endmodule

// File: rtl/xline_router.sv
// Top of the external line router.
// Chain: synchronize lines, detect edges, route triggers to pending bits and event pulses,
// then gate stop entry on the pending summary.
// Assumes stop_req is synchronous to clk.
module xline_router
    import xlr_pkg::*;
#(
    parameter int N          = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      line_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [N-1:0]      wr_data,
    input  logic              stop_req,
    output logic [N-1:0]      irq_req,
    output logic              evt_pulse,
    output logic              any_pend,
    output logic              stop_enter,
    output logic              stop_refuse
);
    logic [N-1:0] sync_in, imask_q, emask_q, rise_q, fall_q, sw_trig, pend_clr;
    logic [N-1:0] trig, pend_q, evt_q;

    xlr_sync #(.WIDTH(N), .STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(line_in), .q(sync_in)
    );

    xlr_cfg #(.N(N)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .imask(imask_q), .emask(emask_q), .rise_en(rise_q), .fall_en(fall_q),
        .sw_trig(sw_trig), .pend_clr(pend_clr)
    );

    xlr_edge #(.N(N)) u_edge (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .rise_en(rise_q), .fall_en(fall_q),
        .sw_trig(sw_trig), .trig(trig)
    );

    xlr_pend #(.N(N)) u_pend (
        .clk(clk), .rst_n(rst_n), .trig(trig), .imask(imask_q), .emask(emask_q),
        .pend_clr(pend_clr), .pend_q(pend_q), .evt_q(evt_q)
    );

    // Output combination: requests, shared event, and stop gating.
    always_comb begin
        irq_req     = pend_q & imask_q;
        evt_pulse   = |evt_q;
        any_pend    = |pend_q;
        stop_enter  = stop_req & ~any_pend;
        stop_refuse = stop_req & any_pend;
    end
endmodule

// File: rtl/xlr_checker.sv
// Property checker for the external line router, attached by bind.
module xlr_checker #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic         stop_req,
    input logic [N-1:0] irq_req,
    input logic         any_pend,
    input logic         stop_enter,
    input logic         stop_refuse,
    input logic [N-1:0] imask_q,
    input logic [N-1:0] pend_q
);
    // R9: grant and refusal never coexist
    a_r9_stop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(stop_enter && stop_refuse));

    // R9: a pending line blocks stop entry
    a_r9_refuse_when_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && any_pend) |-> (stop_refuse && !stop_enter));

    // R7: pending state does not vanish without a write
    a_r7_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (any_pend && !wr_en) |=> any_pend);

    // R5: with no interrupt enables nothing new becomes pending
    a_r5_no_pend_without_imask: assert property (@(posedge clk) disable iff (!rst_n)
        (imask_q == '0 && !any_pend) |=> !any_pend);

    // R6: a request is only raised for a pending line
    a_r6_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req & ~pend_q) == '0);
endmodule

bind xline_router xlr_checker #(.N(N)) u_xlr_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .stop_req(stop_req), .irq_req(irq_req),
    .any_pend(any_pend), .stop_enter(stop_enter), .stop_refuse(stop_refuse),
    .imask_q(imask_q), .pend_q(pend_q)
);

// File: tb/test_xline_router.sv
`timescale 1ns/1ps
module test_xline_router;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic [N-1:0] line_in;
    logic wr_en;
    logic [3:0] wr_addr;
    logic [N-1:0] wr_data;
    logic stop_req;
    logic [N-1:0] irq_req;
    logic evt_pulse, any_pend, stop_enter, stop_refuse;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Model state
    logic [N-1:0] m_s1 = '0, m_s2 = '0, m_s3 = '0;
    logic [N-1:0] m_im = '0, m_em = '0, m_ri = '0, m_fa = '0, m_pend = '0;
    logic m_evt = 1'b0;

    always #2 clk = ~clk;

    xline_router #(.N(N)) i_xline_router (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .stop_req(stop_req), .irq_req(irq_req), .evt_pulse(evt_pulse),
        .any_pend(any_pend), .stop_enter(stop_enter), .stop_refuse(stop_refuse)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [N-1:0] f_trig(input logic [N-1:0] s2, input logic [N-1:0] s3,
                                            input logic [N-1:0] ri, input logic [N-1:0] fa,
                                            input logic [N-1:0] sw);
        return ((s2 & ~s3) & ri) | ((~s2 & s3) & fa) | sw;
    endfunction

    // One cycle: drive at negedge, advance the model at posedge, compare at next negedge.
    task automatic step(input logic [N-1:0] lin, input logic we, input logic [3:0] wa,
                        input logic [N-1:0] wd, input logic sr);
        logic [N-1:0] tr, sw, clr;
        line_in = lin; wr_en = we; wr_addr = wa; wr_data = wd; stop_req = sr;
        @(posedge clk);
        sw  = (we && wa == 4'd8) ? wd : '0;
        clr = (we && wa == 4'd9) ? wd : '0;
        tr  = f_trig(m_s2, m_s3, m_ri, m_fa, sw);
        m_evt  = |(tr & m_em);
        m_pend = (m_pend & ~clr) | (tr & m_im);
        if (we) begin
            case (wa)
                4'd0: m_im = m_im | wd;
                4'd1: m_im = m_im & ~wd;
                4'd2: m_em = m_em | wd;
                4'd3: m_em = m_em & ~wd;
                4'd4: m_ri = m_ri | wd;
                4'd5: m_ri = m_ri & ~wd;
                4'd6: m_fa = m_fa | wd;
                4'd7: m_fa = m_fa & ~wd;
                default: ;
            endcase
        end
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = lin;
        @(negedge clk);
        check("R6/R10 irq_req", 32'(irq_req), 32'(m_pend & m_im));
        check("R4 evt_pulse", 32'(evt_pulse), 32'(m_evt));
        check("R9 any_pend", 32'(any_pend), 32'(|m_pend));
        check("R9 stop_enter", 32'(stop_enter), 32'(sr & ~(|m_pend)));
        check("R9 stop_refuse", 32'(stop_refuse), 32'(sr & (|m_pend)));
    endtask

    task automatic wr(input logic [3:0] wa, input logic [N-1:0] wd);
        step(line_in, 1'b1, wa, wd, 1'b0);
    endtask

    task automatic idle(input logic [N-1:0] lin);
        step(lin, 1'b0, 4'd0, '0, 1'b0);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done) begin
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        logic [N-1:0] lv;
        seed_dummy = $urandom(32'd20240611);
        rst_n = 1'b0; line_in = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; stop_req = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: outputs quiet in reset
        check("R1 irq in reset", 32'(irq_req), 32'd0);
        check("R1 evt in reset", 32'(evt_pulse), 32'd0);
        check("R1 pend in reset", 32'(any_pend), 32'd0);
        rst_n = 1'b1;
        idle('0);

        // R10: program line0 for rising interrupt
        wr(4'd0, 8'h01);
        wr(4'd4, 8'h01);
        // R2: three clocks from pin change to request
        idle(8'h01);
        check("R2 no irq after 1", 32'(irq_req), 32'd0);
        idle(8'h01);
        check("R2 no irq after 2", 32'(irq_req), 32'd0);
        idle(8'h01);
        check("R2 irq after 3", 32'(irq_req), 32'h01);
        // R6: request holds
        idle(8'h01); idle(8'h01);
        check("R6 irq holds", 32'(irq_req), 32'h01);
        // R9: stop refused while pending
        step(8'h01, 1'b0, 4'd0, '0, 1'b1);
        check("R9 refuse", 32'(stop_refuse), 32'd1);
        // R7: writing 0 does nothing, writing 1 clears
        wr(4'd9, 8'h00);
        check("R7 zero no effect", 32'(irq_req), 32'h01);
        wr(4'd9, 8'h01);
        check("R7 clear", 32'(irq_req), 32'd0);
        // R9: stop granted once clear
        step(8'h01, 1'b0, 4'd0, '0, 1'b1);
        check("R9 enter", 32'(stop_enter), 32'd1);
        // R7: falling edge detected in the same cycle as a clear, edge wins
        wr(4'd6, 8'h01);
        idle(8'h00); idle(8'h00);
        step(8'h00, 1'b1, 4'd9, 8'h01, 1'b0);
        check("R7 edge beats clear", 32'(irq_req), 32'h01);
        wr(4'd9, 8'h01);
        check("R7 cleared again", 32'(any_pend), 32'd0);

        // R5: line1 event only, rising
        wr(4'd2, 8'h02);
        wr(4'd4, 8'h02);
        idle(8'h02); idle(8'h02); idle(8'h02);
        check("R4 event pulse", 32'(evt_pulse), 32'd1);
        check("R5 no pending", 32'(any_pend), 32'd0);
        idle(8'h02);
        check("R4 single cycle", 32'(evt_pulse), 32'd0);

        // R8: software trigger on line2 (interrupt only, no edge selects)
        wr(4'd0, 8'h04);
        wr(4'd8, 8'h04);
        check("R8 sw irq", 32'(irq_req), 32'h04);
        check("R8 sw no evt", 32'(evt_pulse), 32'd0);
        wr(4'd8, 8'h02);
        check("R8 sw evt", 32'(evt_pulse), 32'd1);
        wr(4'd9, 8'hFF);

        // R3: both edges on line3, neither on line4
        wr(4'd0, 8'h18);
        wr(4'd4, 8'h08);
        wr(4'd6, 8'h08);
        idle(8'h1A); idle(8'h1A); idle(8'h1A);
        check("R3 rise both", 32'(irq_req), 32'h08);
        wr(4'd9, 8'h08);
        idle(8'h02); idle(8'h02); idle(8'h02);
        check("R3 fall both", 32'(irq_req), 32'h08);
        wr(4'd9, 8'hFF);

        // Random phase, with the model compared every cycle
        lv = 8'h02;
        for (int k = 0; k < 4000; k++) begin
            logic we;
            lv = lv ^ ((($urandom % 4) == 0) ? 8'($urandom) : 8'h00);
            we = (($urandom % 3) == 0);
            step(lv, we, 4'($urandom_range(0, 9)), 8'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule